// File: doc/BRIEF.md
# Multiplexed Nibble Output Formatter

This block sits behind a 12-bit sample converter and puts each converted word onto a 4-bit output bus. Every word arrives with a sample-valid strobe, a 2-bit colour code naming the gain/offset set that produced it, and an overrange flag. The block can optionally replace the word with its 12-bit complement. It can then delay the word by a selectable number of converter-clock periods. Finally it presents the word as four nibbles on consecutive master-clock cycles: three data nibbles, then one status nibble.

A converter-clock period lasts two master clocks in normal operation and three in the fast 3:1 mode. A test mode replaces the data on the bus with four internal timing strobes, so the timing can be checked at the pins. Between words the bus keeps showing the last status nibble. A word that becomes due while another is still going out waits in a one-entry holding register. It starts on the cycle right after the current word's status nibble.

Top module: `nibble_out_fmt`

## Requirements
- R1: While reset is held and in the first cycle after it, with test mode off, the bus reads 4'h0.
- R2: The data nibbles go out one per master clock, in this order: bits 11..8, then 7..4, then 3..0. Each nibble has its most significant bit on pin 3.
- R3: The fourth nibble is {1'b0, colour[1], colour[0], overrange}, so pin 0 carries the overrange flag. The colour codes are 00 red, 01 green and 10 blue; 11 is never presented.
- R4: With the invert bit set, the data nibbles carry 4095 minus the input value. The status nibble is never inverted.
- R5: Take a strobe sampled at rising edge E0, with latency field L (0..3) and P = 2 (normal) or 3 (fast). The first nibble appears just after edge E0+L·P, and until then the bus still shows the previous status nibble.
- R6: After the fourth nibble the bus holds that status nibble until the next word starts.
- R7: A word that becomes due while a sequence is under way is held. Its first nibble follows the current status nibble on the very next cycle.
- R8: In test mode the pins carry the following: pin 3 is the strobe delayed one cycle, and pin 2 is the strobe delayed two cycles. Pin 1 is high for one cycle in every P cycles. Pin 0 is high in the cycle just before each pin-1 pulse. Leaving test mode brings back the held data nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new converted word |
| smp_data | input | 12 | Converted value |
| smp_cc | input | 2 | Colour code of the gain/offset set used |
| smp_ovr | input | 1 | Input exceeded the valid range |
| cfg_invert | input | 1 | Output 4095 minus the value |
| cfg_latency | input | 2 | Extra delay in converter-clock periods |
| cfg_fast | input | 1 | 1: converter clock is three master clocks, else two |
| cfg_test | input | 1 | Route timing strobes to the bus |
| nib_out | output | 4 | Multiplexed output nibble |

## Verification
The assertions rely on a few conditions at the inputs. The colour code is never 11. The configuration is only changed while no word is in flight. Strobes are spaced so that at most one word is waiting while another is going out. The bench follows all three rules. It changes invert, latency and clock ratio only after the previous word has fully drained. It sends words at least four cycles apart, except in the one queueing case. In that case exactly two words arrive two cycles apart, which fills the holding register once without overrunning it.

// File: rtl/nof_pkg.sv
package nof_pkg;
    localparam int DATA_W   = 12;
    localparam int NIB_W    = 4;
    localparam int CC_W     = 2;
    localparam int NIB_N    = DATA_W / NIB_W;
    localparam int SLOT_N   = NIB_N + 1;
    localparam int SLOT_W   = $clog2(SLOT_N);
    localparam int DIV_NORM = 2;
    localparam int DIV_FAST = 3;
    localparam int LAT_W    = 2;
    localparam int LAT_MAX  = (1 << LAT_W) - 1;
    localparam int PIPE_D   = LAT_MAX * DIV_FAST;
    localparam int TAP_W    = $clog2(PIPE_D + 1);
    localparam int PH_W     = $clog2(DIV_FAST);

    typedef enum logic [CC_W-1:0] {
        CC_RED   = 2'b00,
        CC_GREEN = 2'b01,
        CC_BLUE  = 2'b10
    } colour_e;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [CC_W-1:0]   cc;
        logic              ovr;
    } word_t;

    function automatic word_t apply_polarity(word_t w, logic inv);
        word_t r;
        r = w;
        if (inv)
            r.val = {DATA_W{1'b1}} - w.val;
        return r;
    endfunction

    function automatic logic [NIB_W-1:0] pick_nibble(word_t w, logic [SLOT_W-1:0] slot);
        logic [NIB_W-1:0] n;
        n = {1'b0, w.cc, w.ovr};
        for (int k = 0; k < NIB_N; k++) begin
            if (int'(slot) == k)
                n = w.val[DATA_W-1-k*NIB_W -: NIB_W];
        end
        return n;
    endfunction
endpackage

// File: rtl/nof_phase_gen.sv
module nof_phase_gen
    import nof_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic smp_valid,
    output logic conv_pulse,
    output logic rs_pulse,
    output logic sync_q,
    output logic vs_q
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_last;

    assign ph_last = fast ? PH_W'(DIV_FAST - 1) : PH_W'(DIV_NORM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            sync_q <= 1'b0;
            vs_q   <= 1'b0;
        end else begin
            ph_q   <= (ph_q >= ph_last) ? '0 : ph_q + 1'b1;
            sync_q <= smp_valid;
            vs_q   <= sync_q;
        end
    end

    assign conv_pulse = (ph_q == '0);
    assign rs_pulse   = (ph_q == ph_last);
endmodule

// File: rtl/nof_delay_line.sv
module nof_delay_line
    import nof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  word_t            in_word,
    input  logic [LAT_W-1:0] lat,
    input  logic             fast,
    output logic             out_valid,
    output word_t            out_word
);
    logic  v_pipe [PIPE_D+1];
    word_t w_pipe [PIPE_D+1];
    logic [TAP_W-1:0] tap;

    assign v_pipe[0] = in_valid;
    assign w_pipe[0] = in_word;

    for (genvar g = 1; g <= PIPE_D; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v_pipe[g] <= 1'b0;
                w_pipe[g] <= '0;
            end else begin
                v_pipe[g] <= v_pipe[g-1];
                w_pipe[g] <= w_pipe[g-1];
            end
        end
    end

    always_comb begin
        tap = TAP_W'(lat) * (fast ? TAP_W'(DIV_FAST) : TAP_W'(DIV_NORM));
    end

    assign out_valid = v_pipe[tap];
    assign out_word  = w_pipe[tap];
endmodule

// File: rtl/nof_serializer.sv
module nof_serializer
    import nof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  word_t             in_word,
    output logic [NIB_W-1:0]  nib,
    output logic [SLOT_W-1:0] slot,
    output logic              hold_full
);
    logic [SLOT_W-1:0] slot_q;
    word_t             cur_q;
    word_t             hold_q;
    logic              hold_v_q;
    logic              free;
    logic              load;

    assign free = (slot_q == SLOT_W'(SLOT_N - 1));
    assign load = free && (hold_v_q || in_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= SLOT_W'(SLOT_N - 1);
            cur_q    <= '0;
            hold_q   <= '0;
            hold_v_q <= 1'b0;
        end else begin
            if (load) begin
                cur_q  <= hold_v_q ? hold_q : in_word;
                slot_q <= '0;
            end else if (!free) begin
                slot_q <= slot_q + 1'b1;
            end

            if (hold_v_q && load) begin
                hold_v_q <= in_valid;
                hold_q   <= in_word;
            end else if (in_valid && !free) begin
                hold_v_q <= 1'b1;
                hold_q   <= in_word;
            end
        end
    end

    assign nib       = pick_nibble(cur_q, slot_q);
    assign slot      = slot_q;
    assign hold_full = hold_v_q;
endmodule

// File: rtl/nibble_out_fmt.sv
module nibble_out_fmt
    import nof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CC_W-1:0]   smp_cc,
    input  logic              smp_ovr,
    input  logic              cfg_invert,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              cfg_fast,
    input  logic              cfg_test,
    output logic [NIB_W-1:0]  nib_out
);
    word_t             raw_word;
    word_t             pol_word;
    logic              dly_valid;
    word_t             dly_word;
    logic [NIB_W-1:0]  data_nib;
    logic [SLOT_W-1:0] ser_slot;
    logic              ser_hold;
    logic              conv_pulse;
    logic              rs_pulse;
    logic              sync_q;
    logic              vs_q;

    always_comb begin
        raw_word.val = smp_data;
        raw_word.cc  = smp_cc;
        raw_word.ovr = smp_ovr;
        pol_word     = apply_polarity(raw_word, cfg_invert);
    end

    nof_delay_line u_dly (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (smp_valid),
        .in_word   (pol_word),
        .lat       (cfg_latency),
        .fast      (cfg_fast),
        .out_valid (dly_valid),
        .out_word  (dly_word)
    );

    nof_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dly_valid),
        .in_word   (dly_word),
        .nib       (data_nib),
        .slot      (ser_slot),
        .hold_full (ser_hold)
    );

    nof_phase_gen u_ph (
        .clk        (clk),
        .rst        (rst),
        .fast       (cfg_fast),
        .smp_valid  (smp_valid),
        .conv_pulse (conv_pulse),
        .rs_pulse   (rs_pulse),
        .sync_q     (sync_q),
        .vs_q       (vs_q)
    );

    assign nib_out = cfg_test ? {sync_q, vs_q, conv_pulse, rs_pulse} : data_nib;
endmodule

// File: rtl/nof_checker.sv
module nof_checker
    import nof_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic              cfg_test,
    input logic [NIB_W-1:0]  nib_out,
    input logic [SLOT_W-1:0] ser_slot,
    input logic              ser_hold
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOT_N - 1);

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !cfg_test) |-> (nib_out == '0));

    // R2
    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (ser_slot != LAST) |=> (ser_slot == $past(ser_slot) + 1'b1));

    // R3
    a_r3_status_msb: assert property (@(posedge clk) disable iff (rst)
        (!cfg_test && ser_slot == LAST) |-> (nib_out[3] == 1'b0));

    // R3
    a_r3_colour_legal: assert property (@(posedge clk) disable iff (rst)
        (!cfg_test && ser_slot == LAST) |-> (nib_out[2:1] != 2'b11));

    // R7
    a_r7_queue_drain: assert property (@(posedge clk) disable iff (rst)
        (ser_hold && ser_slot == LAST) |=> (ser_slot == '0));

    // R8
    a_r8_conv_pulse: assert property (@(posedge clk) disable iff (rst)
        (cfg_test && nib_out[1]) |=> (!cfg_test || !nib_out[1]));

    // R8
    a_r8_sync_follow: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && cfg_test) |=> (!cfg_test || nib_out[3]));
endmodule

bind nibble_out_fmt nof_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .cfg_test  (cfg_test),
    .nib_out   (nib_out),
    .ser_slot  (ser_slot),
    .ser_hold  (ser_hold)
);

// File: tb/nibble_out_fmt_tb.sv
`timescale 1ns/1ps
module nibble_out_fmt_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [1:0]  smp_cc = '0;
    logic        smp_ovr = 1'b0;
    logic        cfg_invert = 1'b0;
    logic [1:0]  cfg_latency = '0;
    logic        cfg_fast = 1'b0;
    logic        cfg_test = 1'b0;
    logic [3:0]  nib_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] prev_status = 4'h0;

    always #4 clk = ~clk;

    nibble_out_fmt u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_cc(smp_cc), .smp_ovr(smp_ovr), .cfg_invert(cfg_invert),
        .cfg_latency(cfg_latency), .cfg_fast(cfg_fast), .cfg_test(cfg_test),
        .nib_out(nib_out)
    );

    // data, colour, ovr, invert, latency, fast, expected nibbles A B C D
    localparam int NV = 8;
    localparam logic [34:0] VEC [NV] = '{
        {12'hA5C, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'hA5C0},
        {12'h123, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 16'h1232},
        {12'h123, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 16'hEDC5},
        {12'hFFF, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 16'hFFF1},
        {12'h000, 2'd1, 1'b1, 1'b1, 2'd3, 1'b0, 16'hFFF3},
        {12'h800, 2'd2, 1'b0, 1'b0, 2'd1, 1'b1, 16'h8004},
        {12'h7FF, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 16'h8000},
        {12'h3C9, 2'd1, 1'b1, 1'b0, 2'd3, 1'b1, 16'h3C93}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_nib(input string req, input logic [3:0] exp);
        check(nib_out === exp, req, int'(nib_out), int'(exp));
    endtask

    task automatic run_vec(input logic [34:0] v);
        int d;
        logic [15:0] e;
        e = v[15:0];
        d = int'(v[18:17]) * (v[16] ? 3 : 2);
        @(negedge clk);
        smp_data = v[34:23]; smp_cc = v[22:21]; smp_ovr = v[20];
        cfg_invert = v[19]; cfg_latency = v[18:17]; cfg_fast = v[16];
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        // R5: previous status nibble stays until E0+L*P
        if (d > 0) begin
            repeat (d - 1) @(negedge clk);
            chk_nib("R5 before first nibble", prev_status);
            @(negedge clk);
        end
        chk_nib("R2 R4 R5 nibble bits 11..8", e[15:12]);
        @(negedge clk); chk_nib("R2 R4 nibble bits 7..4", e[11:8]);
        @(negedge clk); chk_nib("R2 R4 nibble bits 3..0", e[7:4]);
        @(negedge clk); chk_nib("R3 status nibble", e[3:0]);
        repeat (3) @(negedge clk);
        chk_nib("R6 bus holds status nibble", e[3:0]);
        prev_status = e[3:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk_nib("R1 during reset", 4'h0);
        rst = 1'b0;
        @(negedge clk);
        chk_nib("R1 after reset", 4'h0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R7: second word arrives two cycles after the first
        @(negedge clk);
        cfg_invert = 1'b0; cfg_latency = 2'd0; cfg_fast = 1'b0;
        smp_data = 12'h456; smp_cc = 2'd0; smp_ovr = 1'b0; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0; chk_nib("R7 first word A", 4'h4);
        smp_data = 12'h9AB; smp_cc = 2'd2; smp_ovr = 1'b1;
        @(negedge clk); smp_valid = 1'b1; chk_nib("R7 first word B", 4'h5);
        @(negedge clk); smp_valid = 1'b0; chk_nib("R7 first word C", 4'h6);
        @(negedge clk); chk_nib("R7 first word status", 4'h0);
        @(negedge clk); chk_nib("R7 queued word A", 4'h9);
        @(negedge clk); chk_nib("R7 queued word B", 4'hA);
        @(negedge clk); chk_nib("R7 queued word C", 4'hB);
        @(negedge clk); chk_nib("R7 queued word status", 4'h5);
        prev_status = 4'h5;
        repeat (4) @(negedge clk);

        // R8: converter clock and reset sample clock in both ratios
        for (int f = 0; f < 2; f++) begin
            int p;
            int guard;
            p = (f == 1) ? 3 : 2;
            cfg_fast = f[0];
            cfg_test = 1'b1;
            guard = 0;
            @(negedge clk);
            while (nib_out[1] !== 1'b1 && guard < 8) begin
                @(negedge clk);
                guard++;
            end
            check(nib_out[1] === 1'b1, "R8 converter pulse seen", int'(nib_out[1]), 1);
            for (int k = 1; k <= p; k++) begin
                @(negedge clk);
                check(nib_out[1] === (k == p), "R8 converter pulse period", int'(nib_out[1]), int'(k == p));
                check(nib_out[0] === (k == p - 1), "R8 reset sample pulse", int'(nib_out[0]), int'(k == p - 1));
            end
        end

        // R8: sync and video sample strobes
        cfg_fast = 1'b0;
        smp_data = 12'h000; smp_cc = 2'd0; smp_ovr = 1'b0;
        cfg_latency = 2'd3;
        @(negedge clk);
        check(nib_out[3:2] === 2'b00, "R8 strobes idle", int'(nib_out[3:2]), 0);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check(nib_out[3:2] === 2'b10, "R8 sync one cycle after strobe", int'(nib_out[3:2]), 2);
        @(negedge clk);
        check(nib_out[3:2] === 2'b01, "R8 video sample two cycles after strobe", int'(nib_out[3:2]), 1);
        cfg_test = 1'b0;
        // word is still in the six-cycle delay line: bus shows held nibble
        chk_nib("R8 leaving test mode restores held nibble", prev_status);
        repeat (12) @(negedge clk);
        chk_nib("R8 R6 word sent during test mode ends on its status", 4'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule